// File: doc/BRIEF.md
# Byte/Word Low-Memory Bus Address Decoder

This block sits on the data side of a 16-bit CPU that shares a single address space between code and data. For each access it looks at the 16-bit address and picks one target: the byte-organised special function registers, the 8-bit peripheral window, the 16-bit peripheral window, RAM, or the flash/ROM region. The flash/ROM region includes the interrupt vector table at its top. The block also adapts each byte or word access to the width of the chosen target. It produces a one-hot select, two byte-lane enables, a write enable, lane-aligned write data, and read data merged from the selected target.

Accesses are single-cycle strobes with no back-pressure. A request presented on `req_i` is decoded combinationally in the same cycle, and every target must accept or return data in that cycle. Illegal width/alignment combinations are blocked: no select, no lanes, no write. They are reported by `err_o` in the following cycle. The RAM end and flash start addresses are parameters. Addresses between them belong to no target.

Top module: `pbus_decoder`

## Requirements
- R1: With `req_i` high and no fault, addresses 0x0000–0x000F assert only `sel_sfr_o`, 0x0010–0x00FF only `sel_p8_o`, and 0x0100–0x01FF only `sel_p16_o`. At most one select is ever high.
- R2: Addresses from 0x0200 to `RAM_END` assert `sel_ram_o`, and addresses from `ROM_START` to 0xFFFF assert `sel_rom_o`. Addresses between the two assert no select, give no write enable and read back 0x0000.
- R3: `vec_o` is high, together with `sel_rom_o`, for the top `VEC_WORDS` words (0xFFE0–0xFFFF by default) and low elsewhere.
- R4: A byte access enables lane 2'b01 at an even address and lane 2'b10 at an odd address. Write data is the low input byte copied onto both output bytes.
- R5: A word access at an even address enables lanes 2'b11 and passes write data unchanged. Read data is the target word, with bits 7:0 from the even address and bits 15:8 from the odd address.
- R6: A byte read returns the addressed byte in bits 7:0 and zero in bits 15:8. The addressed byte is the target's bits 7:0 at an even address and bits 15:8 at an odd one. This includes 16-bit peripherals.
- R7: A word access to the 8-bit peripheral window enables only lane 2'b01, so the high write byte is dropped. Bits 15:8 of such a word read are unspecified.
- R8: A word access at an odd address is a fault: no select, lanes 2'b00, `we_o` low, read data 0x0000.
- R9: A word access to the special function register range is a fault, handled as in R8.
- R10: A byte access at an odd address in the 16-bit peripheral window is a fault, handled as in R8.
- R11: `err_o` is low out of reset. It is high for exactly the one cycle after a faulting request and low after every other cycle.
- R12: With `req_i` low there is no select, lanes are 2'b00 and `we_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access strobe, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| byte_i | input | 1 | 1 = byte access, 0 = word access |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 16 | Write data from the CPU |
| sfr_rd_i | input | 16 | Read data from the special function registers |
| p8_rd_i | input | 16 | Read data from the 8-bit peripherals (low byte used) |
| p16_rd_i | input | 16 | Read data from the 16-bit peripherals |
| ram_rd_i | input | 16 | Read data from RAM |
| rom_rd_i | input | 16 | Read data from flash/ROM |
| sel_sfr_o | output | 1 | Special function register select |
| sel_p8_o | output | 1 | 8-bit peripheral select |
| sel_p16_o | output | 1 | 16-bit peripheral select |
| sel_ram_o | output | 1 | RAM select |
| sel_rom_o | output | 1 | Flash/ROM select |
| vec_o | output | 1 | Access lies in the interrupt vector table |
| lane_o | output | 2 | Byte lane enables, bit 0 = even byte |
| we_o | output | 1 | Write enable to the selected target |
| wdata_o | output | 16 | Lane-aligned write data |
| rdata_o | output | 16 | Merged read data to the CPU |
| err_o | output | 1 | Access-error pulse, one cycle after a faulting request |

## Verification
Every region edge is hit from both sides with directed accesses, including the two parameter-defined RAM and flash boundaries and the start of the vector table. These accesses tell an off-by-one range compare from a correct one. Random accesses mix byte and word width, even and odd address, read and write, and all regions including the unmapped gap. The random mix separates the three fault kinds from legal accesses, and lane selection on byte parity from the narrow-lane rule for 8-bit peripherals. Each target's random read data carries distinct high and low bytes, so a swapped byte, a missing zero-fill or a wrong source shows up in the merged result.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;

  // Fixed low-map boundaries (last address of each window)
  localparam logic [ADDR_W-1:0] SFR_LAST = 16'h000F;
  localparam logic [ADDR_W-1:0] P8_LAST  = 16'h00FF;
  localparam logic [ADDR_W-1:0] P16_LAST = 16'h01FF;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_SFR  = 3'd1,
    RG_P8   = 3'd2,
    RG_P16  = 3'd3,
    RG_RAM  = 3'd4,
    RG_ROM  = 3'd5
  } region_e;
endpackage

// File: rtl/pbus_region_dec.sv
module pbus_region_dec import pbus_pkg::*; #(
  parameter logic [ADDR_W-1:0] RAM_END   = 16'h09FF,
  parameter logic [ADDR_W-1:0] ROM_START = 16'hC000,
  parameter int                VEC_WORDS = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic              vec_o
);
  localparam int VEC_BASE_I = (1 << ADDR_W) - 2 * VEC_WORDS;
  localparam logic [ADDR_W-1:0] VEC_BASE = ADDR_W'(VEC_BASE_I);

  always_comb begin
    if (addr_i <= SFR_LAST)       region_o = RG_SFR;
    else if (addr_i <= P8_LAST)   region_o = RG_P8;
    else if (addr_i <= P16_LAST)  region_o = RG_P16;
    else if (addr_i <= RAM_END)   region_o = RG_RAM;
    else if (addr_i >= ROM_START) region_o = RG_ROM;
    else                          region_o = RG_NONE;
  end

  assign vec_o = (addr_i >= VEC_BASE);
endmodule

// File: rtl/pbus_lane_ctl.sv
module pbus_lane_ctl import pbus_pkg::*; (
  input  logic       req_i,
  input  logic       byte_i,
  input  logic       addr0_i,
  input  region_e    region_i,
  output logic       fault_o,
  output logic [1:0] lane_o
);
  always_comb begin
    fault_o = 1'b0;
    if (req_i) begin
      if (!byte_i && addr0_i)                     fault_o = 1'b1; // misaligned word
      if (!byte_i && region_i == RG_SFR)          fault_o = 1'b1; // byte-only window
      if (byte_i && addr0_i && region_i == RG_P16) fault_o = 1'b1; // odd byte on wide periph
    end
    lane_o = 2'b00;
    if (req_i && !fault_o) begin
      if (byte_i)                 lane_o = addr0_i ? 2'b10 : 2'b01;
      else if (region_i == RG_P8) lane_o = 2'b01;
      else                        lane_o = 2'b11;
    end
  end
endmodule

// File: rtl/pbus_rd_merge.sv
module pbus_rd_merge import pbus_pkg::*; (
  input  logic              en_i,
  input  logic              byte_i,
  input  logic              addr0_i,
  input  region_e           region_i,
  input  logic [DATA_W-1:0] sfr_i,
  input  logic [DATA_W-1:0] p8_i,
  input  logic [DATA_W-1:0] p16_i,
  input  logic [DATA_W-1:0] ram_i,
  input  logic [DATA_W-1:0] rom_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HI_W = DATA_W - BYTE_W;
  logic [DATA_W-1:0] src;
  logic [BYTE_W-1:0] pick;

  always_comb begin
    case (region_i)
      RG_SFR:  src = sfr_i;
      RG_P8:   src = p8_i;
      RG_P16:  src = p16_i;
      RG_RAM:  src = ram_i;
      RG_ROM:  src = rom_i;
      default: src = '0;
    endcase
    pick = addr0_i ? src[DATA_W-1:BYTE_W] : src[BYTE_W-1:0];
    if (!en_i)                  rdata_o = '0;
    else if (byte_i)            rdata_o = {{HI_W{1'b0}}, pick};
    else if (region_i == RG_P8) rdata_o = {{HI_W{1'b0}}, src[BYTE_W-1:0]};
    else                        rdata_o = src;
  end
endmodule

// File: rtl/pbus_decoder.sv
module pbus_decoder import pbus_pkg::*; #(
  parameter logic [ADDR_W-1:0] RAM_END   = 16'h09FF,
  parameter logic [ADDR_W-1:0] ROM_START = 16'hC000,
  parameter int                VEC_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] sfr_rd_i,
  input  logic [DATA_W-1:0] p8_rd_i,
  input  logic [DATA_W-1:0] p16_rd_i,
  input  logic [DATA_W-1:0] ram_rd_i,
  input  logic [DATA_W-1:0] rom_rd_i,
  output logic              sel_sfr_o,
  output logic              sel_p8_o,
  output logic              sel_p16_o,
  output logic              sel_ram_o,
  output logic              sel_rom_o,
  output logic              vec_o,
  output logic [1:0]        lane_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  region_e region;
  logic    in_vec;
  logic    fault;
  logic    go;

  pbus_region_dec #(
    .RAM_END(RAM_END), .ROM_START(ROM_START), .VEC_WORDS(VEC_WORDS)
  ) u_dec (
    .addr_i(addr_i), .region_o(region), .vec_o(in_vec)
  );

  pbus_lane_ctl u_lane (
    .req_i(req_i), .byte_i(byte_i), .addr0_i(addr_i[0]),
    .region_i(region), .fault_o(fault), .lane_o(lane_o)
  );

  assign go = req_i && !fault;

  pbus_rd_merge u_merge (
    .en_i(go), .byte_i(byte_i), .addr0_i(addr_i[0]), .region_i(region),
    .sfr_i(sfr_rd_i), .p8_i(p8_rd_i), .p16_i(p16_rd_i),
    .ram_i(ram_rd_i), .rom_i(rom_rd_i), .rdata_o(rdata_o)
  );

  assign sel_sfr_o = go && (region == RG_SFR);
  assign sel_p8_o  = go && (region == RG_P8);
  assign sel_p16_o = go && (region == RG_P16);
  assign sel_ram_o = go && (region == RG_RAM);
  assign sel_rom_o = go && (region == RG_ROM);
  assign vec_o     = go && in_vec;
  assign we_o      = go && wr_i && (region != RG_NONE);
  assign wdata_o   = byte_i ? {2{wdata_i[BYTE_W-1:0]}} : wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= req_i && fault;
  end

  // R1: selects never overlap
  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_sfr_o, sel_p8_o, sel_p16_o, sel_ram_o, sel_rom_o}));
  // R3: vector table lies inside flash/ROM
  p_vec_in_rom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_o |-> sel_rom_o);
  // R6: byte reads zero-fill the upper byte
  p_byte_hi_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && byte_i) |-> (rdata_o[DATA_W-1:BYTE_W] == '0));
  // R7: word access to 8-bit peripherals uses the low lane only
  p_p8_word_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_p8_o && !byte_i) |-> (lane_o == 2'b01));
  // R8: odd word access is blocked
  p_odd_word_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !byte_i && addr_i[0]) |-> (!we_o && lane_o == 2'b00));
  // R9: word access to SFR window is blocked
  p_sfr_word_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !byte_i && addr_i <= SFR_LAST) |-> (!sel_sfr_o && !we_o));
  // R11: a misaligned word access is reported next cycle
  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !byte_i && addr_i[0]) |=> err_o);
  // R12: idle bus is quiet
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |-> (lane_o == 2'b00 && !we_o));
endmodule

// File: tb/pbus_decoder_bench.sv
module pbus_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RAM_END   = 16'h09FF;
  localparam logic [15:0] ROM_START = 16'hC000;
  localparam logic [15:0] VEC_BASE  = 16'hFFE0;

  localparam int G_NONE = 0, G_SFR = 1, G_P8 = 2, G_P16 = 3, G_RAM = 4, G_ROM = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0, byt = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] sfr_rd = '0, p8_rd = '0, p16_rd = '0, ram_rd = '0, rom_rd = '0;
  logic sel_sfr, sel_p8, sel_p16, sel_ram, sel_rom, vec, we, err;
  logic [1:0] lane;
  logic [15:0] wdata_out, rdata;

  int checks = 0;
  int fails = 0;
  logic prev_fault = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbus_decoder #(.RAM_END(RAM_END), .ROM_START(ROM_START), .VEC_WORDS(16)) u_pbus_decoder (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .byte_i(byt),
    .addr_i(addr), .wdata_i(wdata),
    .sfr_rd_i(sfr_rd), .p8_rd_i(p8_rd), .p16_rd_i(p16_rd),
    .ram_rd_i(ram_rd), .rom_rd_i(rom_rd),
    .sel_sfr_o(sel_sfr), .sel_p8_o(sel_p8), .sel_p16_o(sel_p16),
    .sel_ram_o(sel_ram), .sel_rom_o(sel_rom), .vec_o(vec),
    .lane_o(lane), .we_o(we), .wdata_o(wdata_out), .rdata_o(rdata), .err_o(err)
  );

  function automatic int exp_region(input logic [15:0] a);
    if (a <= 16'h000F) return G_SFR;
    if (a <= 16'h00FF) return G_P8;
    if (a <= 16'h01FF) return G_P16;
    if (a <= RAM_END) return G_RAM;
    if (a >= ROM_START) return G_ROM;
    return G_NONE;
  endfunction

  function automatic logic exp_fault(input logic b, input logic [15:0] a);
    int rg = exp_region(a);
    return (!b && a[0]) || (!b && rg == G_SFR) || (b && a[0] && rg == G_P16);
  endfunction

  function automatic logic [15:0] exp_src(input int rg);
    case (rg)
      G_SFR: return sfr_rd;
      G_P8:  return p8_rd;
      G_P16: return p16_rd;
      G_RAM: return ram_rd;
      G_ROM: return rom_rd;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h byte=%0b wr=%0b: actual=%h expected=%h", tag, addr, byt, wr, act, exp);
    end
  endtask

  // Drive at a falling edge, check decode mid-cycle, check err at next falling edge.
  task automatic access(input logic r, input logic w, input logic b,
                        input logic [15:0] a, input logic [15:0] wd);
    int rg;
    logic flt, go;
    logic [4:0] esel;
    logic [1:0] elane;
    logic [15:0] src, erd, mask;
    string ftag, ltag;
    req = r; wr = w; byt = b; addr = a; wdata = wd;
    sfr_rd = 16'($urandom); p8_rd = 16'($urandom); p16_rd = 16'($urandom);
    ram_rd = 16'($urandom); rom_rd = 16'($urandom);
    #(CLK_PERIOD/4);
    rg  = exp_region(a);
    flt = r && exp_fault(b, a);
    go  = r && !flt;
    ftag = (!b && a[0]) ? "R8" : (!b ? "R9" : "R10");
    esel = '0;
    if (go && rg != G_NONE) esel = 5'b00001 << (rg - 1);
    chk({27'd0, sel_rom, sel_ram, sel_p16, sel_p8, sel_sfr}, {27'd0, esel},
        !r ? "R12" : flt ? ftag : (rg <= G_P16 && rg != G_NONE) ? "R1" : "R2");
    chk({31'd0, vec}, {31'd0, go && a >= VEC_BASE}, "R3");
    elane = 2'b00;
    if (go) elane = b ? (a[0] ? 2'b10 : 2'b01) : (rg == G_P8 ? 2'b01 : 2'b11);
    ltag = !r ? "R12" : flt ? ftag : b ? "R4" : (rg == G_P8 ? "R7" : "R5");
    chk({30'd0, lane}, {30'd0, elane}, ltag);
    chk({31'd0, we}, {31'd0, go && w && rg != G_NONE},
        !r ? "R12" : flt ? ftag : (rg == G_NONE ? "R2" : "R5"));
    if (go && w) chk({16'd0, wdata_out}, {16'd0, b ? {2{wd[7:0]}} : wd}, b ? "R4" : "R5");
    if (!w) begin
      src = exp_src(rg);
      mask = 16'hFFFF;
      if (!go || rg == G_NONE) erd = 16'h0000;
      else if (b) erd = {8'h00, a[0] ? src[15:8] : src[7:0]};
      else begin
        erd = src;
        if (rg == G_P8) mask = 16'h00FF;
      end
      chk({16'd0, rdata & mask}, {16'd0, erd & mask},
          flt ? ftag : (!go || rg == G_NONE) ? "R2" : b ? "R6" : "R5");
    end
    @(negedge clk);
    chk({31'd0, err}, {31'd0, flt}, "R11");
    prev_fault = flt;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk({31'd0, err}, 32'd0, "R11");  // reset state
    chk({30'd0, lane}, 32'd0, "R12");
    rst_n = 1'b1;
    @(negedge clk);

    // Directed edges
    access(1, 0, 1, 16'h000F, 16'h0);  // R1 last SFR
    access(1, 0, 1, 16'h0010, 16'h0);  // R1 first P8
    access(1, 0, 0, 16'h00FE, 16'h0);  // R7 word read P8
    access(1, 1, 0, 16'h0020, 16'hBEEF); // R7 word write P8
    access(1, 0, 1, 16'h0100, 16'h0);  // R1 R6 first P16
    access(1, 0, 1, 16'h01FF, 16'h0);  // R10 odd byte P16
    access(1, 0, 0, 16'h01FE, 16'h0);  // R5
    access(1, 0, 0, 16'h0200, 16'h0);  // R2 RAM start
    access(1, 1, 0, RAM_END - 16'd1, 16'h1234); // R2 R5
    access(1, 0, 0, RAM_END + 16'd1, 16'h0);    // R2 gap
    access(1, 1, 0, ROM_START - 16'd2, 16'h5555); // R2 gap no write
    access(1, 0, 0, ROM_START, 16'h0);  // R2 ROM start
    access(1, 0, 0, 16'hFFDE, 16'h0);   // R3 just below vectors
    access(1, 0, 0, 16'hFFE0, 16'h0);   // R3 first vector
    access(1, 0, 1, 16'hFFFF, 16'h0);   // R3 R6 odd byte top
    access(1, 0, 0, 16'h0004, 16'h0);   // R9 SFR word
    access(1, 1, 0, 16'h0301, 16'hAAAA); // R8 odd word write
    access(1, 1, 1, 16'h0303, 16'h00C3); // R4 odd byte write
    access(0, 1, 0, 16'h0300, 16'h0);   // R12 idle
    access(1, 0, 0, 16'hFFFE, 16'h0);   // R3 R11 clears after fault

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      case ($urandom_range(0, 6))
        0: a = 16'($urandom_range(16'h0000, 16'h000F));
        1: a = 16'($urandom_range(16'h0010, 16'h00FF));
        2: a = 16'($urandom_range(16'h0100, 16'h01FF));
        3: a = 16'($urandom_range(16'h0200, 16'(RAM_END)));
        4: a = 16'($urandom_range(16'(RAM_END) + 1, 16'(ROM_START) - 1));
        5: a = 16'($urandom_range(16'(ROM_START), 16'hFFFF));
        default: a = 16'($urandom_range(16'hFFC0, 16'hFFFF));
      endcase
      access($urandom_range(0, 7) != 0, 1'($urandom), 1'($urandom), a, 16'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule